// File: doc/BRIEF.md
# Processor condition flag update unit

This block holds the condition bits of a DSP-style status register together with an overflow-mode control bit. After each arithmetic, logical or shift operation, the execution pipeline presents the operation's result, its raw carry, overflow and underflow indications, the operation class, the shift count and the destination register index. The unit then derives the new per-operation flags and folds overflow and underflow into two sticky copies.

Flags are updated only when the destination is one of the eight extended-precision registers. Any other destination leaves every bit untouched. A direct status write port loads the whole register, and it is the only way to clear the sticky copies. The overflow-mode bit is exported so that the integer datapath can change its behaviour.

Top module: `cfu_flag_unit`

## Requirements
- R1: After a synchronous active-low reset, all seven flag bits and the overflow-mode bit read 0.
- R2: While `sw_we` is high, the next clock loads `flags_o` from `sw_wdata[6:0]` and `ovf_mode_o` from `sw_wdata[7]`. This write takes priority over a flag update in the same cycle. The bit layout of `flags_o` and `sw_wdata` is: [0] carry, [1] overflow, [2] zero, [3] negative, [4] underflow, [5] sticky overflow, [6] sticky underflow.
- R3: A flag update qualifies only when `upd_valid` is high and `dst_idx` is below 8. Without a qualifying update or a direct write, all flags keep their values.
- R4: For integer arithmetic (`op_class` 0): carry equals `raw_carry`, overflow equals `raw_ovf`, underflow is 0, negative is the result MSB, and zero is 1 exactly when the result is all zeros.
- R5: For floating-point arithmetic (`op_class` 1): carry is 0, overflow equals `raw_ovf`, underflow equals `raw_unf`, and negative and zero follow the result as in R4.
- R6: For logical operations (`op_class` 2): carry, overflow and underflow are 0, and negative and zero follow the result.
- R7: For shifts (`op_class` 3): carry equals `raw_carry`, which holds the last bit shifted out, but is forced to 0 when `shift_cnt` is 0. Overflow and underflow are 0, and negative and zero follow the result.
- R8: The sticky overflow bit becomes 1 on a qualifying update whose overflow flag is 1. Otherwise it keeps its value until a direct write.
- R9: The sticky underflow bit becomes 1 on a qualifying update whose underflow flag is 1. Otherwise it keeps its value until a direct write.
- R10: The overflow-mode bit changes only through a direct write.
- R11: New flags appear on `flags_o` one clock after the cycle in which the update strobe was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_valid | input | 1 | Operation result present this cycle |
| op_class | input | 2 | 0 integer, 1 floating-point, 2 logical, 3 shift |
| result | input | DATA_W | Operation output value |
| raw_carry | input | 1 | Carry/borrow, or last bit shifted out |
| raw_ovf | input | 1 | Overflow indication from the execution unit |
| raw_unf | input | 1 | Floating-point underflow indication |
| shift_cnt | input | SHCNT_W | Shift count of a shift operation |
| dst_idx | input | IDX_W | Destination register index |
| sw_we | input | 1 | Direct status register write enable |
| sw_wdata | input | 8 | Direct write data (bit 7 overflow mode) |
| flags_o | output | 7 | Current flag bits |
| ovf_mode_o | output | 1 | Overflow-mode bit |

## Verification
Every piece of state in this unit is a port, so a wrong bit shows up on `flags_o` or `ovf_mode_o` at the very next clock after the operation that caused it. A sticky bit that fails to hold is exposed by a following operation with no overflow or underflow. A gating fault becomes visible when a non-qualifying destination still changes the flags. The scoreboard compares every clocked cycle against a model built from the requirements, and the checker watches hold, priority and shift-carry rules on every edge.

// File: rtl/cfu_pkg.sv
// Package: shared types for the condition flag unit.
// Assumes flag bit order [6:0] = sticky underflow .. carry, as listed in the brief.
package cfu_pkg;

    typedef enum logic [1:0] {
        OPC_INT   = 2'd0,
        OPC_FLT   = 2'd1,
        OPC_LOGIC = 2'd2,
        OPC_SHIFT = 2'd3
    } op_class_e;

    localparam int FLAG_W = 7;

    typedef struct packed {
        logic sunf;   // bit 6 sticky underflow
        logic sovf;   // bit 5 sticky overflow
        logic unf;    // bit 4 underflow
        logic neg;    // bit 3 negative
        logic zero;   // bit 2 zero
        logic ovf;    // bit 1 overflow
        logic carry;  // bit 0 carry
    } flags_t;

endpackage

// File: rtl/cfu_dest_gate.sv
// Module: decides whether an operation may update the flags.
// Assumes the extended-precision registers occupy indices 0..NUM_EXT-1.
module cfu_dest_gate #(
    parameter int IDX_W   = 5,
    parameter int NUM_EXT = 8
) (
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] dst_idx,
    output logic             upd_en
);
    localparam int IDX_SPAN = 1 << IDX_W;

    generate
        if (NUM_EXT >= IDX_SPAN) begin : g_all
            // Every encodable index is an extended register.
            assign upd_en = upd_valid;
        end else begin : g_cmp
            localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_EXT);
            // Qualify only indices below the limit.
            assign upd_en = upd_valid && (dst_idx < LIMIT);
        end
    endgenerate
endmodule

// File: rtl/cfu_flag_calc.sv
// Module: combinational derivation of the next flag set from one operation.
// Assumes raw indications are valid in the same cycle as the result.
module cfu_flag_calc
    import cfu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SHCNT_W = 7
) (
    input  op_class_e          op_class,
    input  logic [DATA_W-1:0]  result,
    input  logic               raw_carry,
    input  logic               raw_ovf,
    input  logic               raw_unf,
    input  logic [SHCNT_W-1:0] shift_cnt,
    input  flags_t             cur_flags,
    output flags_t             nxt_flags
);
    logic res_zero;
    logic res_neg;

    // Result property detection shared by all classes.
    always_comb begin
        res_zero = ~|result;
        res_neg  = result[DATA_W-1];
    end

    // Per-class flag rules plus sticky accumulation.
    always_comb begin
        nxt_flags       = '0;
        nxt_flags.neg   = res_neg;
        nxt_flags.zero  = res_zero;
        unique case (op_class)
            OPC_INT: begin
                nxt_flags.carry = raw_carry;
                nxt_flags.ovf   = raw_ovf;
            end
            OPC_FLT: begin
                nxt_flags.ovf   = raw_ovf;
                nxt_flags.unf   = raw_unf;
            end
            OPC_LOGIC: begin
                nxt_flags.carry = 1'b0;
            end
            OPC_SHIFT: begin
                nxt_flags.carry = (shift_cnt != '0) ? raw_carry : 1'b0;
            end
            default: nxt_flags.carry = 1'b0;
        endcase
        nxt_flags.sovf = cur_flags.sovf | nxt_flags.ovf;
        nxt_flags.sunf = cur_flags.sunf | nxt_flags.unf;
    end
endmodule

// File: rtl/cfu_status_reg.sv
// Module: the flag and overflow-mode storage with write priority.
// Assumes a direct write outranks a flag update in the same cycle.
module cfu_status_reg
    import cfu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_en,
    input  flags_t     nxt_flags,
    input  logic       sw_we,
    input  logic [7:0] sw_wdata,
    output flags_t     flags_q,
    output logic       mode_q
);
    // Flag storage: reset, direct write, or gated update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (sw_we) begin
            flags_q <= flags_t'(sw_wdata[FLAG_W-1:0]);
        end else if (upd_en) begin
            flags_q <= nxt_flags;
        end
    end

    // Overflow-mode storage: changed only by a direct write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (sw_we) begin
            mode_q <= sw_wdata[7];
        end
    end
endmodule

// File: rtl/cfu_flag_unit.sv
// Module: top of the condition flag update unit.
// Assumes one operation per cycle; flags are registered (one-cycle latency).
module cfu_flag_unit
    import cfu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 5,
    parameter int NUM_EXT = 8,
    parameter int SHCNT_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_valid,
    input  logic [1:0]         op_class,
    input  logic [DATA_W-1:0]  result,
    input  logic               raw_carry,
    input  logic               raw_ovf,
    input  logic               raw_unf,
    input  logic [SHCNT_W-1:0] shift_cnt,
    input  logic [IDX_W-1:0]   dst_idx,
    input  logic               sw_we,
    input  logic [7:0]         sw_wdata,
    output logic [6:0]         flags_o,
    output logic               ovf_mode_o
);
    logic      upd_en;
    flags_t    flags_q;
    flags_t    nxt_flags;
    op_class_e opc;

    // Interpret the raw class code.
    assign opc = op_class_e'(op_class);

    cfu_dest_gate #(.IDX_W(IDX_W), .NUM_EXT(NUM_EXT)) u_gate (
        .upd_valid (upd_valid),
        .dst_idx   (dst_idx),
        .upd_en    (upd_en)
    );

    cfu_flag_calc #(.DATA_W(DATA_W), .SHCNT_W(SHCNT_W)) u_calc (
        .op_class  (opc),
        .result    (result),
        .raw_carry (raw_carry),
        .raw_ovf   (raw_ovf),
        .raw_unf   (raw_unf),
        .shift_cnt (shift_cnt),
        .cur_flags (flags_q),
        .nxt_flags (nxt_flags)
    );

    cfu_status_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (upd_en),
        .nxt_flags (nxt_flags),
        .sw_we     (sw_we),
        .sw_wdata  (sw_wdata),
        .flags_q   (flags_q),
        .mode_q    (ovf_mode_o)
    );

    // Export the flag vector.
    assign flags_o = flags_q;
endmodule

// File: rtl/cfu_flag_unit_chk.sv
// Checker: temporal rules of the flag unit, bound to the top module.
module cfu_flag_unit_chk #(
    parameter int IDX_W   = 5,
    parameter int NUM_EXT = 8,
    parameter int SHCNT_W = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               upd_valid,
    input logic [1:0]         op_class,
    input logic [SHCNT_W-1:0] shift_cnt,
    input logic [IDX_W-1:0]   dst_idx,
    input logic               sw_we,
    input logic [7:0]         sw_wdata,
    input logic [6:0]         flags_o,
    input logic               ovf_mode_o
);
    logic qual;
    assign qual = upd_valid && (int'(dst_idx) < NUM_EXT);

    assert_sw_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (flags_o == $past(sw_wdata[6:0])) && (ovf_mode_o == $past(sw_wdata[7])));

    assert_hold_unqualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && !qual) |=> $stable(flags_o));

    assert_shift_zero_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && qual && op_class == 2'd3 && shift_cnt == '0) |=> !flags_o[0]);

    assert_sticky_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[5] && !sw_we) |=> flags_o[5]);

    assert_sticky_unf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[6] && !sw_we) |=> flags_o[6]);

    assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_we |=> $stable(ovf_mode_o));
endmodule

bind cfu_flag_unit cfu_flag_unit_chk #(
    .IDX_W(IDX_W), .NUM_EXT(NUM_EXT), .SHCNT_W(SHCNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .op_class(op_class),
    .shift_cnt(shift_cnt), .dst_idx(dst_idx), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .flags_o(flags_o), .ovf_mode_o(ovf_mode_o)
);

// File: tb/cfu_flag_unit_bench.sv
module cfu_flag_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_valid = 1'b0;
    logic [1:0]  op_class = 2'd0;
    logic [31:0] result = '0;
    logic        raw_carry = 1'b0, raw_ovf = 1'b0, raw_unf = 1'b0;
    logic [6:0]  shift_cnt = '0;
    logic [4:0]  dst_idx = '0;
    logic        sw_we = 1'b0;
    logic [7:0]  sw_wdata = '0;
    logic [6:0]  flags_o;
    logic        ovf_mode_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [6:0] flags;
        logic       mode;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    logic [6:0] m_flags = '0;
    logic       m_mode  = 1'b0;

    always #4 clk = ~clk;

    cfu_flag_unit u_cfu_flag_unit (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .op_class(op_class),
        .result(result), .raw_carry(raw_carry), .raw_ovf(raw_ovf), .raw_unf(raw_unf),
        .shift_cnt(shift_cnt), .dst_idx(dst_idx), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .flags_o(flags_o), .ovf_mode_o(ovf_mode_o)
    );

    // Driver: present one cycle of stimulus and push the expected outcome.
    task automatic drive(input logic uv, input logic [1:0] op, input logic [31:0] res,
                         input logic c, input logic o, input logic u,
                         input logic [6:0] cnt, input logic [4:0] dst,
                         input logic we, input logic [7:0] wd, input string tag);
        logic [6:0] nf;
        exp_t e;
        @(negedge clk);
        upd_valid = uv; op_class = op; result = res; raw_carry = c; raw_ovf = o;
        raw_unf = u; shift_cnt = cnt; dst_idx = dst; sw_we = we; sw_wdata = wd;
        if (we) begin
            m_flags = wd[6:0];
            m_mode  = wd[7];
        end else if (uv && dst < 5'd8) begin
            nf = '0;
            nf[3] = res[31];
            nf[2] = (res == 32'd0);
            case (op)
                2'd0: begin nf[0] = c; nf[1] = o; end
                2'd1: begin nf[1] = o; nf[4] = u; end
                2'd2: ;
                default: nf[0] = (cnt != 7'd0) ? c : 1'b0;
            endcase
            nf[5] = m_flags[5] | nf[1];
            nf[6] = m_flags[6] | nf[4];
            m_flags = nf;
        end
        e.flags = m_flags; e.mode = m_mode; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: one clock after each driven cycle, compare against the scoreboard (R11).
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (flags_o !== e.flags || ovf_mode_o !== e.mode) begin
                errors++;
                $display("FAIL %s: flags=%b mode=%b expected flags=%b mode=%b",
                         e.tag, flags_o, ovf_mode_o, e.flags, e.mode);
            end
        end
    end

    logic finished = 1'b0;

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (flags_o !== 7'd0 || ovf_mode_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: flags=%b mode=%b expected flags=0000000 mode=0", flags_o, ovf_mode_o);
        end
        // R4 R8 R11: integer op, negative result with carry and overflow
        drive(1, 2'd0, 32'h8000_0000, 1, 1, 0, 0, 5'd0, 0, 0, "R4_R8_R11 int neg ovf");
        // R4 R8: zero result, sticky overflow stays
        drive(1, 2'd0, 32'h0, 0, 0, 0, 0, 5'd3, 0, 0, "R4_R8 int zero");
        // R5 R9: float underflow
        drive(1, 2'd1, 32'h0, 1, 0, 1, 0, 5'd7, 0, 0, "R5_R9 float unf");
        // R5: float overflow, negative
        drive(1, 2'd1, 32'hC000_0000, 0, 1, 0, 0, 5'd1, 0, 0, "R5 float ovf");
        // R6: logical ignores raw indications
        drive(1, 2'd2, 32'h0000_0001, 1, 1, 1, 0, 5'd2, 0, 0, "R6 logical");
        drive(1, 2'd2, 32'h0, 1, 0, 0, 0, 5'd2, 0, 0, "R6 logical zero");
        // R7: shift carry rules
        drive(1, 2'd3, 32'h0000_0010, 1, 1, 0, 7'd0, 5'd4, 0, 0, "R7 shift count 0");
        drive(1, 2'd3, 32'h8000_0000, 1, 0, 0, 7'd5, 5'd4, 0, 0, "R7 shift carry 1");
        drive(1, 2'd3, 32'h0, 0, 0, 0, 7'd31, 5'd5, 0, 0, "R7 shift carry 0 zero");
        // R3: non-qualifying destinations and idle cycles leave flags alone
        drive(1, 2'd0, 32'h0, 1, 1, 1, 0, 5'd8, 0, 0, "R3 dst 8");
        drive(1, 2'd1, 32'h1, 0, 1, 1, 0, 5'd31, 0, 0, "R3 dst 31");
        drive(0, 2'd0, 32'h0, 1, 1, 0, 0, 5'd0, 0, 0, "R3 idle");
        // R2 R10: direct write clears sticky bits and sets the mode
        drive(0, 2'd0, 32'h0, 0, 0, 0, 0, 5'd0, 1, 8'h80, "R2_R10 write mode only");
        // R2: write beats a simultaneous update
        drive(1, 2'd0, 32'h0, 1, 1, 0, 0, 5'd0, 1, 8'h15, "R2 write priority");
        // R10: mode holds through updates
        drive(1, 2'd1, 32'h8000_0000, 0, 0, 1, 0, 5'd6, 0, 0, "R10_R9 mode hold");
        drive(0, 2'd0, 32'h0, 0, 0, 0, 0, 5'd0, 1, 8'h7F, "R2 write all flags");
        drive(1, 2'd2, 32'h1234_5678, 0, 0, 0, 0, 5'd0, 0, 0, "R8_R9 sticky after write");
        drive(0, 2'd0, 32'h0, 0, 0, 0, 0, 5'd0, 0, 0, "R3 idle end");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule